// File: doc/BRIEF.md
# Dual-Path Host Bridge Register Bank

This block holds the 64-bit control and status words of a host bridge. Two access paths reach them through one request channel. A sideband configuration path addresses the bank by word index, where the index is the byte address shifted right by three. A memory-mapped path uses byte offsets that are rebased by ten words, so its offset zero lands on the window base register. A select bit chooses the path for each request.

Some indices are not storage but write aliases. One alias ANDs into the error word and another ORs into it. Two further aliases set or clear bits of the control word. The window base register can only be changed from the sideband path. The bank drives its masked address field and enable bit straight out to an external address decoder.

Each request gets exactly one response on the following cycle. Illegal or unknown accesses raise an error flag on that response. A read that cannot be served returns all ones.

Top module: `hb_regbank`

## Requirements
- R1: Only whole 8-byte words are accessed. A request whose byte address has nonzero bits [2:0] is answered with the error flag set and changes no register. Its read data is all ones.
- R2: A sideband request addresses index = byte address >> 3. A memory-mapped request addresses index = (byte address >> 3) + 0x0A, so memory-mapped offset 0x00 reaches the window base register.
- R3: The error word at index 0x00 reads and writes plainly. A write to index 0x01 ANDs the data into it and a write to index 0x02 ORs the data into it. Reads of 0x01 and 0x02 are treated as unimplemented.
- R4: A sideband write to the window base register (index 0x0A) stores the data masked with 0x0003fffffff00000 plus bit 0, the enable. `win_base` shows the masked address field and `win_en` shows bit 0 from the cycle after the write.
- R5: A memory-mapped write to index 0x0A is answered with the error flag and leaves the register, `win_base` and `win_en` unchanged.
- R6: The control word at index 0x0E reads and writes plainly. A write to index 0x12 sets the bits that are one in the data, and a write to index 0x13 clears them.
- R7: Every request cycle yields `rsp_valid` high on exactly the next cycle. With no request, `rsp_valid` is low. Write responses carry zero data.
- R8: A read of an index outside {0x00, 0x06, 0x07, 0x0A, 0x0B, 0x0E, 0x0F, 0x14, 0x15, 0x1B} returns 0xFFFFFFFFFFFFFFFF with the error flag set. A write to an index that has no write meaning is flagged and changes nothing.
- R9: The secondary base register at index 0x0B stores written data masked with 0x0003ffff00000000.
- R10: The interrupt status register at index 0x15 holds `irq_level` at bit positions IRQ_LSB upward, captured every cycle. It is read-only: a write to it is flagged and discarded.
- R11: Indices 0x06, 0x07, 0x0F, 0x14 and 0x1B are plain 64-bit storage, readable and writable from either path.
- R12: After reset every register reads zero, except the window base register, which reads DEF_BASE masked to its address field with the enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_sideband | input | 1 | 1: sideband path indexing, 0: memory-mapped path indexing |
| req_write | input | 1 | 1: write, 0: read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | 64 | Write data |
| irq_level | input | N_SRC | Interrupt source levels sampled into the status register |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Response flags an illegal or unimplemented access |
| rsp_rdata | output | 64 | Read data (all ones on a failed read, zero for writes) |
| win_base | output | 64 | Window base address field for the external decoder |
| win_en | output | 1 | Window enable for the external decoder |

## Verification
A corrupted base register shows on `win_base` or `win_en` one cycle after the faulty update, so the bench compares both after every access. Damage to any other word stays hidden until it is read back, one cycle after the read request. The bench therefore mixes reads into the random traffic so that a wrong value surfaces within a few requests. A decode slip shows up at once as a wrong error flag or as all-ones data on the very next response. Alias and index-rebasing faults show up as a mismatch on the next read of the target word.

// File: rtl/hb_regbank_pkg.sv
// Shared constants and types for the dual-path host bridge register bank.
// Assumes 64-bit words and a native index space of 32 entries.
package hb_regbank_pkg;
    localparam int DW = 64;
    localparam int IW = 5;
    localparam int MMIO_BIAS = 10;

    localparam logic [IW-1:0] IX_ERR     = 5'h00;
    localparam logic [IW-1:0] IX_ERR_AND = 5'h01;
    localparam logic [IW-1:0] IX_ERR_OR  = 5'h02;
    localparam logic [IW-1:0] IX_BAR     = 5'h0A;
    localparam logic [IW-1:0] IX_SBAR    = 5'h0B;
    localparam logic [IW-1:0] IX_CTL     = 5'h0E;
    localparam logic [IW-1:0] IX_CTL_SET = 5'h12;
    localparam logic [IW-1:0] IX_CTL_CLR = 5'h13;
    localparam logic [IW-1:0] IX_STAT    = 5'h15;

    // Plain storage words, slot 0 in the low field.
    localparam int N_PLAIN = 5;
    localparam logic [N_PLAIN*IW-1:0] PLAIN_IDX = {5'h1B, 5'h14, 5'h0F, 5'h07, 5'h06};

    localparam logic [DW-1:0] BAR_ADDR_MASK = 64'h0003_ffff_fff0_0000;
    localparam logic [DW-1:0] BAR_EN_BIT    = 64'h0000_0000_0000_0001;
    localparam logic [DW-1:0] SBAR_MASK     = 64'h0003_ffff_0000_0000;

    typedef enum logic [3:0] {
        WK_NONE,
        WK_ERR_WR,
        WK_ERR_AND,
        WK_ERR_OR,
        WK_CTL_WR,
        WK_CTL_SET,
        WK_CTL_CLR,
        WK_BAR,
        WK_SBAR,
        WK_PLAIN
    } wkind_e;
endpackage

// File: rtl/hb_index_xlate.sv
// Maps a request byte address into the shared word index space.
// Sideband requests use the word number as is; memory-mapped requests are
// rebased by MMIO_BIAS words. Assumes ADDR_W > 3.
module hb_index_xlate
    import hb_regbank_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              via_sideband,
    output logic [IDX_W-1:0]  word_idx,
    output logic              aligned
);
    // Word number plus the path-dependent rebase (one spare bit, no wrap).
    always_comb begin
        word_idx = IDX_W'(byte_addr[ADDR_W-1:3]);
        if (!via_sideband) begin
            word_idx = word_idx + IDX_W'(MMIO_BIAS);
        end
    end

    assign aligned = (byte_addr[2:0] == 3'b000);
endmodule

// File: rtl/hb_access_decode.sv
// Classifies a word index as readable and/or by its write action.
// Assumes indices at or above 2**IW are unimplemented. A write kind of
// WK_NONE means the write is illegal (unknown, read-only, or locked path).
module hb_access_decode
    import hb_regbank_pkg::*;
#(
    parameter int IDX_W = 14
) (
    input  logic [IDX_W-1:0]   word_idx,
    input  logic               via_sideband,
    input  logic               aligned,
    output logic               rd_ok,
    output wkind_e             wr_kind,
    output logic [N_PLAIN-1:0] plain_hit
);
    logic          in_range;
    logic [IW-1:0] nidx;
    logic          rd_known;
    wkind_e        kind;

    assign in_range = ((word_idx >> IW) == '0);
    assign nidx     = word_idx[IW-1:0];

    // One comparator per plain storage slot.
    for (genvar g = 0; g < N_PLAIN; g++) begin : g_hit
        assign plain_hit[g] = in_range && (nidx == PLAIN_IDX[g*IW +: IW]);
    end

    // Decode readability and write action of the special indices.
    always_comb begin
        kind     = WK_NONE;
        rd_known = 1'b0;
        if (in_range) begin
            case (nidx)
                IX_ERR:     begin rd_known = 1'b1; kind = WK_ERR_WR; end
                IX_ERR_AND: kind = WK_ERR_AND;
                IX_ERR_OR:  kind = WK_ERR_OR;
                IX_BAR:     begin rd_known = 1'b1; kind = via_sideband ? WK_BAR : WK_NONE; end
                IX_SBAR:    begin rd_known = 1'b1; kind = WK_SBAR; end
                IX_CTL:     begin rd_known = 1'b1; kind = WK_CTL_WR; end
                IX_CTL_SET: kind = WK_CTL_SET;
                IX_CTL_CLR: kind = WK_CTL_CLR;
                IX_STAT:    rd_known = 1'b1;
                default:    ;
            endcase
        end
        if (|plain_hit) begin
            rd_known = 1'b1;
            kind     = WK_PLAIN;
        end
    end

    assign rd_ok   = aligned && rd_known;
    assign wr_kind = aligned ? kind : WK_NONE;
endmodule

// File: rtl/hb_reg_store.sv
// Holds the bank's registers and applies one write action per cycle.
// Assumes wr_kind is WK_NONE whenever no legal write is present.
module hb_reg_store
    import hb_regbank_pkg::*;
#(
    parameter logic [DW-1:0] DEF_BASE = 64'h0001_2345_6780_0000,
    parameter int            N_SRC    = 5,
    parameter int            IRQ_LSB  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wkind_e             wr_kind,
    input  logic [N_PLAIN-1:0] plain_hit,
    input  logic [DW-1:0]      wdata,
    input  logic [N_SRC-1:0]   irq_level,
    output logic [DW-1:0]      err_q,
    output logic [DW-1:0]      ctl_q,
    output logic [DW-1:0]      bar_q,
    output logic [DW-1:0]      sbar_q,
    output logic [DW-1:0]      stat_q,
    output logic [DW-1:0]      plain_q [N_PLAIN]
);
    localparam logic [DW-1:0] BAR_KEEP  = BAR_ADDR_MASK | BAR_EN_BIT;
    localparam logic [DW-1:0] BAR_RESET = (DEF_BASE & BAR_ADDR_MASK) | BAR_EN_BIT;

    // Error word: plain write, AND alias, OR alias.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            case (wr_kind)
                WK_ERR_WR:  err_q <= wdata;
                WK_ERR_AND: err_q <= err_q & wdata;
                WK_ERR_OR:  err_q <= err_q | wdata;
                default:    ;
            endcase
        end
    end

    // Control word: plain write, set alias, clear alias.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            case (wr_kind)
                WK_CTL_WR:  ctl_q <= wdata;
                WK_CTL_SET: ctl_q <= ctl_q | wdata;
                WK_CTL_CLR: ctl_q <= ctl_q & ~wdata;
                default:    ;
            endcase
        end
    end

    // Window base: loads its enabled default on reset, masked on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_q <= BAR_RESET;
        end else if (wr_kind == WK_BAR) begin
            bar_q <= wdata & BAR_KEEP;
        end
    end

    // Secondary base: masked storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sbar_q <= '0;
        end else if (wr_kind == WK_SBAR) begin
            sbar_q <= wdata & SBAR_MASK;
        end
    end

    // Interrupt status: tracks the source levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= DW'(irq_level) << IRQ_LSB;
        end
    end

    for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
        // Plain storage slot g: load on its own write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                plain_q[g] <= '0;
            end else if (wr_kind == WK_PLAIN && plain_hit[g]) begin
                plain_q[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/hb_regbank.sv
// Top of the dual-path host bridge register bank.
// One request per cycle; the path select bit chooses the index mapping.
// The response is registered and appears on the following cycle.
// Assumes IRQ_LSB + N_SRC <= 64.
module hb_regbank
    import hb_regbank_pkg::*;
#(
    parameter int            ADDR_W   = 16,
    parameter logic [63:0]   DEF_BASE = 64'h0001_2345_6780_0000,
    parameter int            N_SRC    = 5,
    parameter int            IRQ_LSB  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_sideband,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    input  logic [N_SRC-1:0]  irq_level,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic [63:0]       win_base,
    output logic              win_en
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]   word_idx;
    logic               aligned;
    logic               rd_ok;
    wkind_e             wr_kind;
    wkind_e             wr_act;
    logic [N_PLAIN-1:0] plain_hit;
    logic [DW-1:0]      err_q, ctl_q, bar_q, sbar_q, stat_q;
    logic [DW-1:0]      plain_q [N_PLAIN];
    logic [DW-1:0]      rd_word;
    logic               bad_req;

    hb_index_xlate #(.ADDR_W(ADDR_W)) u_xlate (
        .byte_addr    (req_addr),
        .via_sideband (req_sideband),
        .word_idx     (word_idx),
        .aligned      (aligned)
    );

    hb_access_decode #(.IDX_W(IDX_W)) u_decode (
        .word_idx     (word_idx),
        .via_sideband (req_sideband),
        .aligned      (aligned),
        .rd_ok        (rd_ok),
        .wr_kind      (wr_kind),
        .plain_hit    (plain_hit)
    );

    // Only a present write request may act on the store.
    assign wr_act = (req_valid && req_write) ? wr_kind : WK_NONE;

    hb_reg_store #(.DEF_BASE(DEF_BASE), .N_SRC(N_SRC), .IRQ_LSB(IRQ_LSB)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_kind   (wr_act),
        .plain_hit (plain_hit),
        .wdata     (req_wdata),
        .irq_level (irq_level),
        .err_q     (err_q),
        .ctl_q     (ctl_q),
        .bar_q     (bar_q),
        .sbar_q    (sbar_q),
        .stat_q    (stat_q),
        .plain_q   (plain_q)
    );

    // Read multiplexer; all ones unless the index is readable.
    always_comb begin
        rd_word = '1;
        if (rd_ok) begin
            case (word_idx[IW-1:0])
                IX_ERR:  rd_word = err_q;
                IX_BAR:  rd_word = bar_q;
                IX_SBAR: rd_word = sbar_q;
                IX_CTL:  rd_word = ctl_q;
                IX_STAT: rd_word = stat_q;
                default: rd_word = '1;
            endcase
            for (int s = 0; s < N_PLAIN; s++) begin
                if (plain_hit[s]) rd_word = plain_q[s];
            end
        end
    end

    assign bad_req = req_write ? (wr_kind == WK_NONE) : !rd_ok;

    // Registered response: valid, error pulse and data one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && bad_req;
            rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
        end
    end

    assign win_base = bar_q & BAR_ADDR_MASK;
    assign win_en   = bar_q[0];
endmodule

// File: rtl/hb_regbank_chk.sv
// Port-level properties of the register bank, bound to every instance.
module hb_regbank_chk #(
    parameter int ADDR_W = 16,
    parameter int N_SRC  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_sideband,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [63:0]       req_wdata,
    input logic [N_SRC-1:0]  irq_level,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic [63:0]       win_base,
    input logic              win_en
);
    localparam logic [ADDR_W-1:0] SB_BAR_ADDR = ADDR_W'(8'h50);

    // R7: a request is always answered on the next cycle
    a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7: no response without a request
    a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    // R8: error flag only travels with a response
    a_r8_err_has_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid);

    // R8: a failed read returns all ones
    a_r8_err_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_err && !$past(req_write)) |-> (rsp_rdata == '1));

    // R1: partial-word addresses are always flagged
    a_r1_misaligned_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[2:0] != 3'b000) |=> rsp_err);

    // R5: memory-mapped writes cannot move the window
    a_r5_mmio_bar_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_sideband && req_addr == '0)
        |=> (rsp_err && $stable(win_base) && $stable(win_en)));

    // R4: sideband write to the base sets the exported enable
    a_r4_bar_en_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sideband && req_addr == SB_BAR_ADDR)
        |=> (!rsp_err && win_en == $past(req_wdata[0])));
endmodule

bind hb_regbank hb_regbank_chk #(.ADDR_W(ADDR_W), .N_SRC(N_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_sideband (req_sideband),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .irq_level    (irq_level),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .win_base     (win_base),
    .win_en       (win_en)
);

// File: tb/hb_regbank_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases, then seeded random traffic,
// all compared against a bench-side model of the register bank.
module hb_regbank_tb_top;
    localparam int          ADDR_W   = 16;
    localparam logic [63:0] DEF_BASE = 64'h0001_2345_6780_0000;
    localparam int          N_SRC    = 5;
    localparam int          IRQ_LSB  = 32;
    localparam logic [63:0] BMASK    = 64'h0003_ffff_fff0_0000;
    localparam logic [63:0] SMASK    = 64'h0003_ffff_0000_0000;
    localparam logic [63:0] ONES     = 64'hffff_ffff_ffff_ffff;

    logic              clk;
    logic              rst_n;
    logic              req_valid;
    logic              req_sideband;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [63:0]       req_wdata;
    logic [N_SRC-1:0]  irq_level;
    logic              rsp_valid;
    logic              rsp_err;
    logic [63:0]       rsp_rdata;
    logic [63:0]       win_base;
    logic              win_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [63:0] mdl [0:31];

    hb_regbank #(.ADDR_W(ADDR_W), .DEF_BASE(DEF_BASE), .N_SRC(N_SRC), .IRQ_LSB(IRQ_LSB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sideband(req_sideband),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .irq_level(irq_level), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .win_base(win_base), .win_en(win_en)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic bit rd_legal(input int ix);
        return ix == 'h00 || ix == 'h06 || ix == 'h07 || ix == 'h0A || ix == 'h0B ||
               ix == 'h0E || ix == 'h0F || ix == 'h14 || ix == 'h15 || ix == 'h1B;
    endfunction

    function automatic bit wr_legal(input int ix, input bit sb);
        if (ix == 'h0A) return sb;
        return ix == 'h00 || ix == 'h01 || ix == 'h02 || ix == 'h06 || ix == 'h07 ||
               ix == 'h0B || ix == 'h0E || ix == 'h0F || ix == 'h12 || ix == 'h13 ||
               ix == 'h14 || ix == 'h1B;
    endfunction

    task automatic model_write(input int ix, input logic [63:0] d);
        case (ix)
            'h01: mdl[0]   = mdl[0] & d;
            'h02: mdl[0]   = mdl[0] | d;
            'h0A: mdl[10]  = d & (BMASK | 64'h1);
            'h0B: mdl[11]  = d & SMASK;
            'h12: mdl[14]  = mdl[14] | d;
            'h13: mdl[14]  = mdl[14] & ~d;
            default: mdl[ix] = d;
        endcase
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drives one request at a falling edge and checks the response one cycle later.
    task automatic access(input bit sb, input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [63:0] d, input string tag);
        int ix;
        bit ok;
        logic [63:0] exp_d;
        ix = int'(a >> 3) + (sb ? 0 : 10);
        if (wr) begin
            ok = (a[2:0] == 3'b000) && wr_legal(ix, sb);
            exp_d = '0;
            if (ok) model_write(ix, d);
        end else begin
            ok = (a[2:0] == 3'b000) && rd_legal(ix);
            exp_d = ok ? mdl[ix] : ONES;
        end
        req_valid = 1'b1; req_sideband = sb; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " rsp_valid (R7)"}, 64'(rsp_valid), 64'd1);
        check({tag, " rsp_err"}, 64'(rsp_err), 64'(!ok));
        check({tag, " rsp_rdata"}, rsp_rdata, exp_d);
        check({tag, " win_base (R4)"}, win_base, mdl[10] & BMASK);
        check({tag, " win_en (R4)"}, 64'(win_en), 64'(mdl[10][0]));
    endtask

    task automatic set_irq(input logic [N_SRC-1:0] v);
        irq_level = v;
        mdl[21] = 64'(v) << IRQ_LSB;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        mdl[10] = (DEF_BASE & BMASK) | 64'h1;
        rst_n = 1'b0; req_valid = 1'b0; req_sideband = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; irq_level = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state at the ports and on every readable word
        check("R12 rsp_valid idle", 64'(rsp_valid), 64'd0);
        check("R12 win_en", 64'(win_en), 64'd1);
        check("R12 win_base", win_base, DEF_BASE & BMASK);
        access(1, 0, 16'h0050, '0, "R12 base");
        access(1, 0, 16'h0000, '0, "R12 err");
        access(1, 0, 16'h0070, '0, "R12 ctl");
        access(1, 0, 16'h00D8, '0, "R12 plain");

        // R2: memory-mapped offset 0 is the base, offset 8 the secondary base
        access(0, 0, 16'h0000, '0, "R2 mmio base");
        access(0, 0, 16'h0008, '0, "R2 mmio sbar");
        access(0, 1, 16'h0020, 64'h1234_5678_9abc_def0, "R2 mmio ctl write");
        access(1, 0, 16'h0070, '0, "R2 sideband ctl readback");

        // R3: error word with AND and OR aliases
        access(1, 1, 16'h0000, 64'hf0f0_f0f0_0000_ffff, "R3 err write");
        access(1, 1, 16'h0008, 64'hff00_ff00_ffff_00ff, "R3 err and");
        access(1, 1, 16'h0010, 64'h0000_0001_0000_0000, "R3 err or");
        access(1, 0, 16'h0000, '0, "R3 err read");
        check("R3 err literal", mdl[0], 64'hf000_f001_0000_00ff);
        access(1, 0, 16'h0008, '0, "R3 alias read");

        // R4 / R5: sideband owns the base register
        access(1, 1, 16'h0050, ONES, "R4 base all ones");
        access(1, 0, 16'h0050, '0, "R4 base read");
        check("R4 base literal", mdl[10], 64'h0003_ffff_fff0_0001);
        access(1, 1, 16'h0050, 64'h0000_1000_0010_0000, "R4 base disable");
        access(0, 1, 16'h0000, ONES, "R5 mmio base write");
        access(0, 0, 16'h0000, '0, "R5 base unchanged");

        // R6: control set and clear aliases via the memory-mapped path
        access(0, 1, 16'h0040, 64'h8000_0000_0000_0003, "R6 ctl set");
        access(0, 1, 16'h0048, 64'h0000_0000_0000_00f1, "R6 ctl clear");
        access(1, 0, 16'h0070, '0, "R6 ctl read");

        // R8: unimplemented indices
        access(1, 0, 16'h00F8, '0, "R8 read idx 1f");
        access(0, 0, 16'h00B8, '0, "R8 mmio read idx 21");
        access(1, 1, 16'h0018, ONES, "R8 write idx 03");
        access(1, 0, 16'h0090, '0, "R8 read set alias");

        // R10: status is read-only and tracks the levels
        set_irq(5'b10101);
        access(1, 0, 16'h00A8, '0, "R10 status read");
        access(1, 1, 16'h00A8, '0, "R10 status write");
        access(0, 0, 16'h0058, '0, "R10 status after write");

        // R1: partial-word addresses
        access(1, 0, 16'h0054, '0, "R1 misaligned read");
        access(1, 1, 16'h0001, 64'h0, "R1 misaligned write");
        access(1, 0, 16'h0000, '0, "R1 err word unchanged");

        // R9: secondary base mask
        access(1, 1, 16'h0058, ONES, "R9 sbar write");
        access(0, 0, 16'h0008, '0, "R9 sbar read");

        // R11: plain words across both paths
        access(0, 1, 16'h0088, 64'hdead_beef_0bad_f00d, "R11 mmio write 1b");
        access(1, 0, 16'h00D8, '0, "R11 sideband read 1b");
        access(1, 1, 16'h0078, 64'h0123_4567_89ab_cdef, "R11 sideband write 0f");
        access(0, 0, 16'h0028, '0, "R11 mmio read 0f");

        // R7: idle cycle has no response
        @(negedge clk);
        check("R7 idle", 64'(rsp_valid), 64'd0);

        // Random mix over both paths
        set_irq(5'b01011);
        for (int n = 0; n < 3000; n++) begin
            bit sb;
            bit wr;
            logic [ADDR_W-1:0] a;
            sb = $urandom_range(1, 0) == 1;
            wr = $urandom_range(1, 0) == 1;
            a = sb ? ADDR_W'($urandom_range(35, 0) * 8) : ADDR_W'($urandom_range(23, 0) * 8);
            if ($urandom_range(15, 0) == 0) a[2:0] = 3'($urandom_range(7, 0));
            access(sb, wr, a, {$urandom, $urandom}, "R2 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule